// File: doc/BRIEF.md
# Flash Completion Status Poller

This block runs on the host side of a NOR flash. After software or another engine has issued a program or erase, it watches the flash status until the operation ends. Each status read goes out on a simple read port that allows one request in flight. The block compares the returned status bits against the rules of the selected algorithm. When the operation has ended, it raises a one-cycle `done_o` with `error_o` giving the verdict.

Two algorithms are available, chosen at start by `mode_i`:

- **Data polling** compares status bit 7 with bit 7 of the expected data.
- **Toggle polling** reads status in pairs and looks for bit 6 to stop changing.

In both modes, bit 5 (the flash's internal time-limit flag) does not end the operation by itself. The completion bit can settle in the same read that bit 5 rises, so the block always reads again before it reports a failure.

For an erase, load the expected data with FFh and use an address inside the erased sector. For a whole-chip erase, that address must lie in a sector that is not protected. An optional poll-count watchdog ends an operation that never shows completion or bit 5.

Top module: `fcs_poller`

## Requirements
- R1: After reset `busy_o`, `done_o`, `error_o` and `rd_req_o` are all 0.
- R2: A start pulse taken while idle captures `addr_i`, and every read of that operation uses that address on `rd_addr_o`. A start pulse while `busy_o` is 1 is ignored: the address, the mode, the number of reads and the verdict do not change.
- R3: In data mode (`mode_i`=0), a read whose bit 7 equals bit 7 of `exp_data_i` ends the operation with `error_o`=0.
- R4: In data mode, a read whose bit 7 differs and whose bit 5 is 1 is followed by exactly one more read. The operation passes if that read's bit 7 matches, and fails with `error_o`=1 otherwise.
- R5: In toggle mode (`mode_i`=1), status is read in consecutive pairs. A pair with equal bit 6 ends the operation with `error_o`=0.
- R6: In toggle mode, a pair whose bit 6 differs and whose second read has bit 5 = 1 is followed by exactly one more pair. The operation passes if bit 6 is equal in that pair, and fails otherwise.
- R7: When `WDOG_POLLS` checks in a row end with neither completion nor bit 5 (a check is one read in data mode, one pair in toggle mode), the operation ends with `error_o`=1 and no further read. A value of 0 disables this limit.
- R8: `done_o` is a single-cycle pulse, and `error_o` is 1 only while `done_o` is 1. `busy_o` is 1 from the cycle after an accepted start until the cycle in which `done_o` rises, where it is 0.
- R9: `rd_req_o` is a one-cycle pulse issued only while busy. No new request is made until `rd_valid_i` has returned the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (taken only when idle) |
| mode_i | input | 1 | 0 = data polling on bit 7, 1 = toggle polling on bit 6 |
| addr_i | input | ADDR_W | Address to poll |
| exp_data_i | input | DATA_W | Data that was written (FFh for erase) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| error_o | output | 1 | With done_o: 1 = failure or watchdog |
| rd_req_o | output | 1 | Read request pulse |
| rd_addr_o | output | ADDR_W | Read address |
| rd_valid_i | input | 1 | Read data returned |
| rd_data_i | input | DATA_W | Returned status byte |

## Verification
The bench sweeps both modes against a flash model. The sweep covers every completion latency up to ten reads, every onset of bit 5 in the same range, and expected data that flips bits 7 and 6.

The key corner is bit 5 rising in the same read as the last busy status, followed by true data. A design that trusted bit 5 alone would report a failure there, and one that skipped the recheck would show one read too few. In toggle mode, a pair formed from the last toggle and the first array data must pass when bit 6 happens to match. The never-finishing cases must stop after exactly the watchdog count.

A start pulse is also injected mid-operation; a design that accepted it would change the address or the read count.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int BIT_DONE = 7;
  localparam int BIT_TOG  = 6;
  localparam int BIT_TMO  = 5;

  typedef enum logic {
    POLL_DATA   = 1'b0,
    POLL_TOGGLE = 1'b1
  } poll_mode_e;

  typedef enum logic [2:0] {
    VD_MORE,
    VD_POLL,
    VD_RECHK,
    VD_PASS,
    VD_FAIL
  } verdict_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } ctrl_state_e;

  typedef struct packed {
    logic done_bit;
    logic tog_bit;
    logic tmo_bit;
  } status_t;
endpackage

// File: rtl/fcs_judge.sv
module fcs_judge
  import fcs_pkg::*;
(
  input  poll_mode_e mode_i,
  input  logic       half_i,
  input  logic       rechk_i,
  input  logic       exp_done_i,
  input  logic       prev_tog_i,
  input  status_t    stat_i,
  output verdict_e   verdict_o
);
  logic settled;

  always_comb begin
    if (mode_i == POLL_DATA) settled = (stat_i.done_bit == exp_done_i);
    else                     settled = (stat_i.tog_bit == prev_tog_i);
  end

  always_comb begin
    if (mode_i == POLL_TOGGLE && !half_i) verdict_o = VD_MORE;
    else if (settled)                     verdict_o = VD_PASS;
    else if (rechk_i)                     verdict_o = VD_FAIL;
    else if (stat_i.tmo_bit)              verdict_o = VD_RECHK;
    else                                  verdict_o = VD_POLL;
  end
endmodule

// File: rtl/fcs_watchdog.sv
module fcs_watchdog #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic expired_o
);
  generate
    if (LIMIT == 0) begin : g_off
      assign expired_o = 1'b0;
    end else begin : g_on
      localparam int CNT_W = $clog2(LIMIT + 1);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (inc_i) cnt_q <= cnt_q + 1'b1;
      end

      assign expired_o = inc_i && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  poll_mode_e        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              exp_done_i,
  input  logic              rd_valid_i,
  input  status_t           stat_i,
  input  verdict_e          verdict_i,
  input  logic              wd_expired_i,
  output poll_mode_e        mode_o,
  output logic              half_o,
  output logic              rechk_o,
  output logic              exp_done_o,
  output logic              prev_tog_o,
  output logic              accept_o,
  output logic              poll_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  ctrl_state_e       st_q;
  poll_mode_e        mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic              exp_q, half_q, rechk_q, prev_q, done_q, err_q;
  logic              rsp;

  assign accept_o = (st_q == ST_IDLE) && start_i;
  assign rsp      = (st_q == ST_WAIT) && rd_valid_i;
  assign poll_o   = rsp && (verdict_i == VD_POLL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      mode_q  <= POLL_DATA;
      addr_q  <= '0;
      exp_q   <= 1'b0;
      half_q  <= 1'b0;
      rechk_q <= 1'b0;
      prev_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q    <= ST_ISSUE;
          mode_q  <= mode_i;
          addr_q  <= addr_i;
          exp_q   <= exp_done_i;
          half_q  <= 1'b0;
          rechk_q <= 1'b0;
        end
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: if (rsp) begin
          unique case (verdict_i)
            VD_MORE: begin
              prev_q <= stat_i.tog_bit;
              half_q <= 1'b1;
              st_q   <= ST_ISSUE;
            end
            VD_POLL: begin
              half_q <= 1'b0;
              if (wd_expired_i) begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
                err_q  <= 1'b1;
              end else begin
                st_q <= ST_ISSUE;
              end
            end
            VD_RECHK: begin
              half_q  <= 1'b0;
              rechk_q <= 1'b1;
              st_q    <= ST_ISSUE;
            end
            VD_PASS: begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end
            default: begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end
          endcase
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mode_o     = mode_q;
  assign half_o     = half_q;
  assign rechk_o    = rechk_q;
  assign exp_done_o = exp_q;
  assign prev_tog_o = prev_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign error_o    = err_q;
  assign rd_req_o   = (st_q == ST_ISSUE);
  assign rd_addr_o  = addr_q;
endmodule

// File: rtl/fcs_poller.sv
module fcs_poller
  import fcs_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int DATA_W     = 8,
  parameter int WDOG_POLLS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] exp_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i
);
  status_t    stat;
  verdict_e   verdict;
  poll_mode_e mode_q;
  logic       half, rechk, exp_q, prev_tog, accept, poll, wd_exp;
  logic       unused_bits;

  assign stat = '{done_bit: rd_data_i[BIT_DONE],
                  tog_bit:  rd_data_i[BIT_TOG],
                  tmo_bit:  rd_data_i[BIT_TMO]};
  assign unused_bits = ^{rd_data_i, exp_data_i};

  fcs_judge u_judge (
    .mode_i     (mode_q),
    .half_i     (half),
    .rechk_i    (rechk),
    .exp_done_i (exp_q),
    .prev_tog_i (prev_tog),
    .stat_i     (stat),
    .verdict_o  (verdict)
  );

  fcs_watchdog #(.LIMIT(WDOG_POLLS)) u_wdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept),
    .inc_i     (poll),
    .expired_o (wd_exp)
  );

  fcs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .mode_i       (poll_mode_e'(mode_i)),
    .addr_i       (addr_i),
    .exp_done_i   (exp_data_i[BIT_DONE]),
    .rd_valid_i   (rd_valid_i),
    .stat_i       (stat),
    .verdict_i    (verdict),
    .wd_expired_i (wd_exp),
    .mode_o       (mode_q),
    .half_o       (half),
    .rechk_o      (rechk),
    .exp_done_o   (exp_q),
    .prev_tog_o   (prev_tog),
    .accept_o     (accept),
    .poll_o       (poll),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .error_o      (error_o),
    .rd_req_o     (rd_req_o),
    .rd_addr_o    (rd_addr_o)
  );
endmodule

// File: rtl/fcs_poller_chk.sv
module fcs_poller_chk #(
  parameter int ADDR_W = 21
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              error_o,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_valid_i
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (rd_req_o)   pend_q <= 1'b1;
    else if (rd_valid_i) pend_q <= 1'b0;
  end

  a_r8_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> done_o);
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_idle_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r8_busy_ends_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r9_req_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> busy_o);
  a_r9_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !pend_q);
  a_r9_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  a_r2_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));
endmodule

bind fcs_poller fcs_poller_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .error_o    (error_o),
  .rd_req_o   (rd_req_o),
  .rd_addr_o  (rd_addr_o),
  .rd_valid_i (rd_valid_i)
);

// File: tb/fcs_poller_tb_top.sv
module fcs_poller_tb_top;
  localparam int AW = 21;
  localparam int DW = 8;
  localparam int WD = 6;
  localparam int NEVER = 1000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] exp_d = '0;
  logic          busy, done, err, rd_req, rd_valid;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  int checks = 0, fails = 0, cycles = 0;
  int rd_cnt = 0, base = 0, m_done = NEVER, m_tmo = NEVER;
  logic [DW-1:0] m_exp = '0;
  logic [AW-1:0] m_addr = '0;
  bit            addr_bad = 1'b0;
  logic          v1 = 1'b0;
  logic [DW-1:0] d1 = '0;

  always #4 clk = ~clk;

  fcs_poller #(.ADDR_W(AW), .DATA_W(DW), .WDOG_POLLS(WD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .addr_i(addr), .exp_data_i(exp_d), .busy_o(busy), .done_o(done),
    .error_o(err), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data));

  // status byte of read number i of the current operation
  function automatic logic [DW-1:0] mbyte(int i, logic [DW-1:0] e, int d_at, int t_at);
    logic [DW-1:0] b;
    if (i >= d_at) return e;
    b    = ~e;
    b[6] = i[0];
    b[5] = (i >= t_at);
    return b;
  endfunction

  // flash model: two-cycle read latency
  always @(posedge clk) begin
    cycles   <= cycles + 1;
    v1       <= rd_req;
    d1       <= mbyte(rd_cnt - base, m_exp, m_done, m_tmo);
    rd_valid <= v1;
    rd_data  <= d1;
    if (rd_req) begin
      rd_cnt <= rd_cnt + 1;
      if (rd_addr !== m_addr) addr_bad <= 1'b1;
    end
  end

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // expected verdict and read count from the requirements
  task automatic predict(bit md, logic [DW-1:0] e, int d_at, int t_at,
                         output bit x_err, output int x_rd, output string tag);
    int i = 0, c = 0;
    logic [DW-1:0] a, b, p, q;
    x_err = 0; x_rd = 0; tag = md ? "R5" : "R3";
    for (int g = 0; g < 100; g++) begin
      if (!md) begin
        a = mbyte(i, e, d_at, t_at);
        if (a[7] == e[7]) begin x_rd = i + 1; return; end
        if (a[5]) begin
          b = mbyte(i + 1, e, d_at, t_at);
          x_err = (b[7] != e[7]); x_rd = i + 2; tag = "R4"; return;
        end
        c++;
        if (c == WD) begin x_err = 1; x_rd = i + 1; tag = "R7"; return; end
        i++;
      end else begin
        a = mbyte(i, e, d_at, t_at);
        b = mbyte(i + 1, e, d_at, t_at);
        if (a[6] == b[6]) begin x_rd = i + 2; return; end
        if (b[5]) begin
          p = mbyte(i + 2, e, d_at, t_at);
          q = mbyte(i + 3, e, d_at, t_at);
          x_err = (p[6] != q[6]); x_rd = i + 4; tag = "R6"; return;
        end
        c++;
        if (c == WD) begin x_err = 1; x_rd = i + 2; tag = "R7"; return; end
        i += 2;
      end
    end
  endtask

  task automatic run_op(bit md, logic [AW-1:0] a, logic [DW-1:0] e,
                        int d_at, int t_at, bit poke);
    bit x_err; int x_rd; string tag; int n = 0; bit got_err;
    predict(md, e, d_at, t_at, x_err, x_rd, tag);
    @(negedge clk);
    m_exp = e; m_done = d_at; m_tmo = t_at; m_addr = a; base = rd_cnt;
    addr_bad = 1'b0;
    mode = md; addr = a; exp_d = e; start = 1'b1;
    @(negedge clk);
    start = 1'b0; mode = 1'b0; addr = '0; exp_d = '0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; mode = ~md; addr = ~a; exp_d = ~e;
      @(negedge clk);
      start = 1'b0; addr = '0;
    end
    while (!done && n < 2000) begin
      if (err) chk(0, "R8", 1, 0);
      @(negedge clk); n++;
    end
    chk(done, "R8", done, 1);
    chk(!busy, "R8", busy, 0);
    got_err = err;
    chk(got_err == x_err, poke ? "R2" : tag, got_err, x_err);
    chk(rd_cnt - base == x_rd, poke ? "R2" : tag, rd_cnt - base, x_rd);
    chk(!addr_bad, "R2", addr_bad, 0);
    @(negedge clk);
    chk(!done && !err, "R8", done, 0);
  endtask

  initial begin
    #1;
    chk(!busy && !done && !err && !rd_req, "R1", busy + done + err + rd_req, 0);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !rd_req, "R1", busy + done + err + rd_req, 0);
    rst_n = 1'b1;
    // R2: start while busy ignored
    run_op(1'b0, 21'h0A5A5A, 8'hFF, 5, NEVER, 1'b1);
    run_op(1'b1, 21'h155555, 8'h3C, 6, 3, 1'b1);
    // R3..R7 sweep (R9 via assertions)
    for (int md = 0; md < 2; md++)
      for (int ei = 0; ei < 3; ei++)
        for (int d = 0; d <= 10; d++)
          for (int t = 0; t <= 10; t++)
            run_op(md[0], AW'(d * 37 + t * 1013 + ei),
                   (ei == 0) ? 8'hFF : (ei == 1) ? 8'h3C : 8'h40,
                   (d == 10) ? NEVER : d, (t == 10) ? NEVER : t, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule